// File: doc/BRIEF.md
# Supervisor Timer Compare Interrupt Unit

This unit raises the two timer-pending bits of a hart's supervisor level: one for the host supervisor and one for a virtualized guest supervisor. A shared 64-bit time value arrives on every cycle. The unit holds a per-guest time offset and two compare registers, one for each pending bit. Each pending bit is re-evaluated in hardware whenever the time moves or one of the registers is written. Software therefore never needs to poll or re-arm the bit.

The same offset adder also produces the time value a reader sees. A guest sees the shifted time, and any other reader sees the raw time. The unit also decides whether an access to a compare register is allowed, based on two environment enable bits, one at machine level and one at hypervisor level. It reports a disallowed access as either an illegal-instruction fault or a virtual-instruction fault.

All outputs are registered. Each output reflects the inputs and register writes of the previous clock cycle.

Top module: `stimer_cmp_unit`

## Requirements
- R1: While `menv_tce` is 1, `stip` is 1 exactly when `time_in` is greater than or equal to the supervisor compare register. The comparison is unsigned over 64 bits.
- R2: `vstip` is 1 exactly when (`time_in` + offset) modulo 2^64 is greater than or equal to the guest compare register. The comparison is unsigned.
- R3: A write to a compare register or to the offset register takes effect in the comparison on the same edge that stores it. Every output shows the result one clock after its inputs are presented.
- R4: `time_rd` equals `time_in` + offset (wrapping) when `virt` is 1, and `time_in` otherwise, one clock later.
- R5: While `menv_tce` is 1, a software pending write (`sw_pend_wr_en`) leaves the stored software bit unchanged. While `menv_tce` is 0, `stip` shows the stored software bit, and such a write updates that bit.
- R6: An access (`acc_valid`=1) with `priv` not equal to 2'b11 (machine) while `menv_tce` is 0 sets `fault_illegal` for one cycle, one clock later.
- R7: An access with `priv` not machine, `menv_tce`=1, `henv_tce`=0 and `virt`=1 sets `fault_virtual` (not `fault_illegal`) one clock later.
- R8: A machine-level access, a permitted access or no access leaves both fault outputs at 0. The two faults are never 1 together.
- R9: Synchronous reset sets both compare registers to all ones, the offset to 0, the software bit to 0, and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_in | input | 64 | Shared time value |
| delta_wr_en | input | 1 | Write strobe for the guest time offset |
| delta_wr_data | input | 64 | New guest time offset |
| scmp_wr_en | input | 1 | Write strobe for the supervisor compare register |
| scmp_wr_data | input | 64 | New supervisor compare value |
| vscmp_wr_en | input | 1 | Write strobe for the guest compare register |
| vscmp_wr_data | input | 64 | New guest compare value |
| menv_tce | input | 1 | Machine-level timer compare enable |
| henv_tce | input | 1 | Hypervisor-level timer compare enable |
| virt | input | 1 | Hart runs in virtualized mode |
| priv | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| acc_valid | input | 1 | An access to a compare register is being made |
| sw_pend_wr_en | input | 1 | Software write of the supervisor pending bit |
| sw_pend_wr_val | input | 1 | Value of that software write |
| stip | output | 1 | Supervisor timer pending |
| vstip | output | 1 | Guest supervisor timer pending |
| time_rd | output | 64 | Time value as seen by the current reader |
| fault_illegal | output | 1 | Illegal-instruction fault for the access |
| fault_virtual | output | 1 | Virtual-instruction fault for the access |

## Verification
Every result of this unit passes through exactly one register. The pending bits, the read-time value and both fault flags are all due on the first rising edge after the stimulus is presented. This includes the case where the stimulus is a register write, because the comparison uses the value being written.

The bench presents each stimulus after a falling edge and lets one rising edge pass. It samples at the next falling edge, so each check lands on the first cycle the result is due. The bench then removes the write strobes, so a later check cannot be satisfied by a strobe left over from an earlier one.

// File: rtl/stimer_pkg.sv
package stimer_pkg;
  typedef logic [1:0] priv_t;
  localparam priv_t PRIV_M = 2'b11;

  typedef struct packed {
    logic illegal;
    logic virt;
  } fault_t;
endpackage

// File: rtl/stimer_cmp_lane.sv
// One compare register plus its comparator; compares against the value
// about to be stored so a write is reflected on the same edge.
module stimer_cmp_lane #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_data,
  input  logic [TW-1:0] cur_time,
  output logic          hit
);
  logic [TW-1:0] cmp_q, cmp_nx;

  assign cmp_nx = wr_en ? wr_data : cmp_q;
  assign hit    = (cur_time >= cmp_nx);

  always_ff @(posedge clk) begin
    if (rst) cmp_q <= '1;
    else     cmp_q <= cmp_nx;
  end
endmodule

// File: rtl/stimer_access_chk.sv
// Access permission for compare registers, registered.
module stimer_access_chk
  import stimer_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   acc_valid,
  input  priv_t  priv,
  input  logic   virt,
  input  logic   menv_tce,
  input  logic   henv_tce,
  output fault_t fault_q
);
  fault_t fault_nx;
  logic   below_m;

  always_comb begin
    below_m          = (priv != PRIV_M);
    fault_nx.illegal = acc_valid && below_m && !menv_tce;
    fault_nx.virt    = acc_valid && below_m && menv_tce && !henv_tce && virt;
  end

  always_ff @(posedge clk) begin
    if (rst) fault_q <= '0;
    else     fault_q <= fault_nx;
  end
endmodule

// File: rtl/stimer_cmp_unit.sv
module stimer_cmp_unit #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] time_in,
  input  logic          delta_wr_en,
  input  logic [TW-1:0] delta_wr_data,
  input  logic          scmp_wr_en,
  input  logic [TW-1:0] scmp_wr_data,
  input  logic          vscmp_wr_en,
  input  logic [TW-1:0] vscmp_wr_data,
  input  logic          menv_tce,
  input  logic          henv_tce,
  input  logic          virt,
  input  logic [1:0]    priv,
  input  logic          acc_valid,
  input  logic          sw_pend_wr_en,
  input  logic          sw_pend_wr_val,
  output logic          stip,
  output logic          vstip,
  output logic [TW-1:0] time_rd,
  output logic          fault_illegal,
  output logic          fault_virtual
);
  import stimer_pkg::*;

  localparam int NLANE = 2;
  localparam int LANE_S = 0;
  localparam int LANE_V = 1;

  logic [TW-1:0]    delta_q, delta_nx, guest_now;
  logic [TW-1:0]    lane_time [NLANE];
  logic [NLANE-1:0] lane_we;
  logic [TW-1:0]    lane_wd   [NLANE];
  logic [NLANE-1:0] lane_hit;
  logic             sw_stip_q, sw_stip_nx, sw_take;
  logic             stip_q, vstip_q;
  logic [TW-1:0]    time_rd_q;
  fault_t           fault_q;

  // guest time uses the offset value being stored this edge
  assign delta_nx  = delta_wr_en ? delta_wr_data : delta_q;
  assign guest_now = time_in + delta_nx;

  assign lane_time[LANE_S] = time_in;
  assign lane_we[LANE_S]   = scmp_wr_en;
  assign lane_wd[LANE_S]   = scmp_wr_data;
  assign lane_time[LANE_V] = guest_now;
  assign lane_we[LANE_V]   = vscmp_wr_en;
  assign lane_wd[LANE_V]   = vscmp_wr_data;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    stimer_cmp_lane #(.TW(TW)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (lane_we[g]),
      .wr_data  (lane_wd[g]),
      .cur_time (lane_time[g]),
      .hit      (lane_hit[g])
    );
  end

  // software path to the pending bit is only open while the compare is off
  assign sw_take    = sw_pend_wr_en && !menv_tce;
  assign sw_stip_nx = sw_take ? sw_pend_wr_val : sw_stip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      delta_q   <= '0;
      sw_stip_q <= 1'b0;
      stip_q    <= 1'b0;
      vstip_q   <= 1'b0;
      time_rd_q <= '0;
    end else begin
      delta_q   <= delta_nx;
      sw_stip_q <= sw_stip_nx;
      stip_q    <= menv_tce ? lane_hit[LANE_S] : sw_stip_nx;
      vstip_q   <= lane_hit[LANE_V];
      time_rd_q <= virt ? guest_now : time_in;
    end
  end

  stimer_access_chk u_acc (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .priv      (priv),
    .virt      (virt),
    .menv_tce  (menv_tce),
    .henv_tce  (henv_tce),
    .fault_q   (fault_q)
  );

  assign stip          = stip_q;
  assign vstip         = vstip_q;
  assign time_rd       = time_rd_q;
  assign fault_illegal = fault_q.illegal;
  assign fault_virtual = fault_q.virt;
endmodule

// File: rtl/stimer_cmp_chk.sv
module stimer_cmp_chk #(
  parameter int TW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic [TW-1:0] time_in,
  input logic          menv_tce,
  input logic          henv_tce,
  input logic          virt,
  input logic [1:0]    priv,
  input logic          acc_valid,
  input logic          sw_pend_wr_en,
  input logic          sw_stip_q,
  input logic [TW-1:0] time_rd,
  input logic          fault_illegal,
  input logic          fault_virtual
);
  assert_illegal_R6: assert property (@(posedge clk) disable iff (rst)
    acc_valid && priv != 2'b11 && !menv_tce |=> fault_illegal);

  assert_virtual_R7: assert property (@(posedge clk) disable iff (rst)
    acc_valid && priv != 2'b11 && menv_tce && !henv_tce && virt
    |=> fault_virtual && !fault_illegal);

  assert_mmode_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    acc_valid && priv == 2'b11 |=> !fault_illegal && !fault_virtual);

  assert_fault_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fault_illegal, fault_virtual}));

  assert_sw_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    menv_tce && sw_pend_wr_en |=> $stable(sw_stip_q));

  assert_raw_time_R4: assert property (@(posedge clk) disable iff (rst)
    !virt |=> time_rd == $past(time_in));
endmodule

bind stimer_cmp_unit stimer_cmp_chk #(.TW(TW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .time_in       (time_in),
  .menv_tce      (menv_tce),
  .henv_tce      (henv_tce),
  .virt          (virt),
  .priv          (priv),
  .acc_valid     (acc_valid),
  .sw_pend_wr_en (sw_pend_wr_en),
  .sw_stip_q     (sw_stip_q),
  .time_rd       (time_rd),
  .fault_illegal (fault_illegal),
  .fault_virtual (fault_virtual)
);

// File: tb/sim_stimer_cmp_unit.sv
module sim_stimer_cmp_unit;
  localparam int TW = 64;
  localparam logic [63:0] ONES = '1;

  logic clk = 0, rst = 1;
  logic [TW-1:0] time_in = '0, delta_wr_data = '0, scmp_wr_data = '0, vscmp_wr_data = '0;
  logic delta_wr_en = 0, scmp_wr_en = 0, vscmp_wr_en = 0;
  logic menv_tce = 0, henv_tce = 0, virt = 0, acc_valid = 0;
  logic [1:0] priv = 2'b00;
  logic sw_pend_wr_en = 0, sw_pend_wr_val = 0;
  logic stip, vstip, fault_illegal, fault_virtual;
  logic [TW-1:0] time_rd;
  int nvec = 0, nerr = 0;

  always #4 clk = ~clk;

  stimer_cmp_unit #(.TW(TW)) u0 (.*);

  typedef struct packed {
    logic [63:0] tm, sc, vc, dl;
    logic        vr, es, ev;
    logic [63:0] gt;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{64'd100, 64'd100, 64'd200, 64'd0, 1'b0, 1'b1, 1'b0, 64'd100},
    '{64'd99,  64'd100, 64'd50,  64'd0, 1'b0, 1'b0, 1'b1, 64'd99},
    '{64'd10,  64'd5,   64'd30,  64'd20, 1'b1, 1'b1, 1'b1, 64'd30},
    '{64'd10,  64'd11,  64'd31,  64'd20, 1'b1, 1'b0, 1'b0, 64'd30},
    '{64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h11, 64'h20, 1'b1, 1'b0, 1'b0, 64'h10},
    '{64'h8000_0000_0000_0000, 64'd1, 64'h8000_0000_0000_0000, 64'd0, 1'b0, 1'b1, 1'b1, 64'h8000_0000_0000_0000},
    '{64'd0, 64'd0, 64'd0, 64'd0, 1'b0, 1'b1, 1'b1, 64'd0},
    '{64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 64'd4}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one rising edge, then sample at the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    delta_wr_en = 0; scmp_wr_en = 0; vscmp_wr_en = 0;
    sw_pend_wr_en = 0; acc_valid = 0;
  endtask

  task automatic access(input logic [1:0] p, input logic v, input logic m, input logic h,
                        input logic ei, input logic ev, input string req);
    priv = p; virt = v; menv_tce = m; henv_tce = h; acc_valid = 1;
    tick();
    chk({req, " fault_illegal"}, 64'(fault_illegal), 64'(ei));
    chk({req, " fault_virtual"}, 64'(fault_virtual), 64'(ev));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    tick();
    // R9: reset state, compare regs all ones so nothing pending at time 0
    chk("R9 stip", 64'(stip), 0);
    chk("R9 vstip", 64'(vstip), 0);
    chk("R9 time_rd", time_rd, 0);
    chk("R9 fault_illegal", 64'(fault_illegal), 0);
    chk("R9 fault_virtual", 64'(fault_virtual), 0);
    menv_tce = 1; time_in = ONES;
    tick();
    chk("R9 stip at max time", 64'(stip), 1);
    chk("R9 vstip at max time", 64'(vstip), 1);
    time_in = ONES - 1;
    tick();
    chk("R9 stip below max", 64'(stip), 0);
    chk("R9 vstip below max", 64'(vstip), 0);

    // vector table: R1, R2, R4
    for (int i = 0; i < 8; i++) begin
      time_in = VEC[i].tm; virt = VEC[i].vr; menv_tce = 1;
      scmp_wr_en = 1; scmp_wr_data = VEC[i].sc;
      vscmp_wr_en = 1; vscmp_wr_data = VEC[i].vc;
      delta_wr_en = 1; delta_wr_data = VEC[i].dl;
      tick();
      chk($sformatf("R1 stip vec%0d", i), 64'(stip), 64'(VEC[i].es));
      chk($sformatf("R2 vstip vec%0d", i), 64'(vstip), 64'(VEC[i].ev));
      chk($sformatf("R4 time_rd vec%0d", i), time_rd, VEC[i].gt);
    end

    // R3: compare write alone, then time move alone
    virt = 0; time_in = 50; scmp_wr_en = 1; scmp_wr_data = 50;
    tick();
    chk("R3 write equal", 64'(stip), 1);
    scmp_wr_en = 1; scmp_wr_data = 51;
    tick();
    chk("R3 write above", 64'(stip), 0);
    time_in = 51;
    tick();
    chk("R3 time reaches", 64'(stip), 1);
    delta_wr_en = 1; delta_wr_data = 0; vscmp_wr_en = 1; vscmp_wr_data = 60;
    tick();
    chk("R3 vstip below", 64'(vstip), 0);
    delta_wr_en = 1; delta_wr_data = 9;
    tick();
    chk("R3 offset write", 64'(vstip), 1);

    // R5: software path
    scmp_wr_en = 1; scmp_wr_data = ONES; menv_tce = 0;
    sw_pend_wr_en = 1; sw_pend_wr_val = 1;
    tick();
    chk("R5 sw set", 64'(stip), 1);
    sw_pend_wr_en = 1; sw_pend_wr_val = 0;
    tick();
    chk("R5 sw clear", 64'(stip), 0);
    sw_pend_wr_en = 1; sw_pend_wr_val = 1;
    tick();
    menv_tce = 1;
    tick();
    chk("R5 compare drives", 64'(stip), 0);
    sw_pend_wr_en = 1; sw_pend_wr_val = 0;
    tick();
    chk("R5 ignored write", 64'(stip), 0);
    menv_tce = 0;
    tick();
    chk("R5 stored bit kept", 64'(stip), 1);

    // R6, R7, R8: access faults
    access(2'b00, 0, 0, 0, 1, 0, "R6 user tce0");
    access(2'b01, 1, 0, 1, 1, 0, "R6 guest tce0");
    access(2'b01, 1, 1, 0, 0, 1, "R7 guest henv0");
    access(2'b01, 1, 1, 1, 0, 0, "R8 guest allowed");
    access(2'b11, 0, 0, 0, 0, 0, "R8 machine");
    access(2'b01, 0, 1, 0, 0, 0, "R8 host henv0");
    priv = 2'b00; menv_tce = 0;
    tick();
    chk("R8 no access", 64'(fault_illegal | fault_virtual), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule